// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block divides a source clock by a fixed-point divisor with a 12-bit integer part and a 12-bit fractional part. A 2-bit mode input picks how the fractional part is used. In integer mode it is ignored. In first-order mode the periods alternate between the integer value and one more than it. In the second- and third-order noise-shaped modes each period comes from a cascade of three fractional accumulators. The carries of that cascade are combined through first and second differences, so the period moves inside a small window around the integer part and the fractional error is pushed toward high frequencies.

A new divide value is taken at every output period boundary. Divisor and mode may change at any time, and the change appears at the next boundary. Dropping the enable stops the output low and clears the modulator, so the sequence starts again in a known state. Each output period is high for half its length, rounded down, and low for the rest.

Top module: `mash_clk_div`

## Requirements
- R1: The divisor word carries the integer part I in bits 23:12 and the fractional part F in bits 11:0. The mode input selects 0 = integer, 1 = first order, 2 = second order, 3 = third order.
- R2: In mode 0 every output period is I source cycles long, whatever F is (for I >= 2).
- R3: In mode 1, output period n (n = 1 for the first period after enable) lasts I + floor(n*F/4096) - floor((n-1)*F/4096) cycles, so it is always I or I+1.
- R4: In mode 1 the total length of any 4096 consecutive output periods is exactly 4096*I + F cycles.
- R5: In mode 2 every output period lies between I-1 and I+2 cycles (for I >= 3).
- R6: In mode 3 every output period lies between I-3 and I+4 cycles (for I >= 5).
- R7: In modes 2 and 3 the first 4096 output periods after enable total between 4096*I+F-1 and 4096*I+F+2 cycles.
- R8: No output period is shorter than 2 cycles. A divide value below 2 is raised to 2.
- R9: Each output period of length P is high for floor(P/2) cycles and then low for the remaining cycles.
- R10: A change of divisor or mode made inside a period leaves that period's length unchanged and applies from the next period.
- R11: With reset asserted or enable low, the output is low (from the first clock edge after enable falls), and the modulator accumulators are cleared.
- R12: In modes 2 and 3 with F = 0, every output period is exactly I cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable. Low stops the output and clears the modulator |
| divWord | input | 24 | Divisor: integer part in 23:12, fraction in 11:0 |
| modeSel | input | 2 | Modulation order: 0 integer, 1 first, 2 second, 3 third |
| divClk | output | 1 | Divided clock |

## Verification
The hardest behaviour to reach is the long-run accounting. The exact 4096-period sum in first-order mode, and the bounded residue in the higher orders, only show up after the accumulators have wrapped through a full cycle. The bench therefore uses small integer parts with odd fractions and runs each order for more than 4096 periods from a fresh enable, recording every period's length and high time. A mid-period divisor change is timed from an observed rising edge so that it falls strictly inside a long period. A restart after a run with a dirty accumulator state then shows, through the exact first-order formula, that disabling really cleared the modulator.

// File: rtl/mash_div_pkg.sv
package mash_div_pkg;

  typedef enum logic [1:0] {
    MODE_INT   = 2'd0,
    MODE_FRAC1 = 2'd1,
    MODE_MASH2 = 2'd2,
    MODE_MASH3 = 2'd3
  } divMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // take a new period value, advance modulator
    logic clear;  // hold modulator at zero
  } divStrobe_t;

endpackage

// File: rtl/mash_div_datapath.sv
module mash_div_datapath
  import mash_div_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12,
  parameter int LEN_W  = INT_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  divStrobe_t              strobe,
  input  logic [INT_W+FRAC_W-1:0] divWord,
  input  divMode_e                mode,
  output logic [LEN_W-1:0]        nextLen
);

  localparam int STAGES = 3;
  localparam logic signed [LEN_W:0] MIN_LEN = 2;

  logic [INT_W-1:0]               intPart;
  logic [FRAC_W-1:0]              fracPart;
  logic [STAGES-1:0][FRAC_W-1:0]  addend;
  logic [STAGES-1:0][FRAC_W-1:0]  sumLo;
  logic [STAGES-1:0]              carry;
  logic                           c2Prev;
  logic                           c3Prev;
  logic                           c3Prev2;

  assign intPart  = divWord[FRAC_W +: INT_W];
  assign fracPart = divWord[FRAC_W-1:0];

  // cascade of accumulators, each fed by the running sum of the previous one
  for (genvar g = 0; g < STAGES; g++) begin : gStage
    logic [FRAC_W-1:0] accR;
    logic [FRAC_W:0]   sumW;

    if (g == 0) begin : gFirst
      assign addend[g] = fracPart;
    end else begin : gNext
      assign addend[g] = sumLo[g-1];
    end

    assign sumW     = {1'b0, accR} + {1'b0, addend[g]};
    assign sumLo[g] = sumW[FRAC_W-1:0];
    assign carry[g] = sumW[FRAC_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             accR <= '0;
      else if (strobe.clear) accR <= '0;
      else if (strobe.step)  accR <= sumW[FRAC_W-1:0];
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clear |=> (accR == '0)); // R11
  end

  // carry history for the difference terms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2Prev  <= 1'b0;
      c3Prev  <= 1'b0;
      c3Prev2 <= 1'b0;
    end else if (strobe.clear) begin
      c2Prev  <= 1'b0;
      c3Prev  <= 1'b0;
      c3Prev2 <= 1'b0;
    end else if (strobe.step) begin
      c2Prev  <= carry[1];
      c3Prev  <= carry[2];
      c3Prev2 <= c3Prev;
    end
  end

  logic signed [3:0] termOne;
  logic signed [3:0] termTwo;
  logic signed [3:0] termThree;
  logic signed [3:0] offSel;
  logic signed [LEN_W:0] target;

  always_comb begin
    termOne   = $signed({3'b000, carry[0]});
    termTwo   = $signed({3'b000, carry[1]}) - $signed({3'b000, c2Prev});
    termThree = $signed({3'b000, carry[2]}) - $signed({2'b00, c3Prev, 1'b0})
              + $signed({3'b000, c3Prev2});
    unique case (mode)
      MODE_INT:   offSel = 4'sd0;
      MODE_FRAC1: offSel = termOne;
      MODE_MASH2: offSel = termOne + termTwo;
      default:    offSel = termOne + termTwo + termThree;
    endcase
    target = $signed({2'b00, intPart}) + $signed({{(LEN_W-3){offSel[3]}}, offSel});
    if (target < MIN_LEN) nextLen = LEN_W'(2);
    else                  nextLen = target[LEN_W-1:0];
  end

endmodule

// File: rtl/mash_div_ctrl.sv
module mash_div_ctrl
  import mash_div_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [LEN_W-1:0] nextLen,
  output divStrobe_t       strobe,
  output logic             divClk
);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] curLen;
  logic             running;
  logic             clkQ;

  assign strobe.step  = en && (!running || (cnt == curLen - 1'b1));
  assign strobe.clear = !en;
  assign divClk       = clkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      curLen  <= LEN_W'(2);
      clkQ    <= 1'b0;
    end else if (!en) begin
      running <= 1'b0;
      cnt     <= '0;
      clkQ    <= 1'b0;
    end else if (strobe.step) begin
      running <= 1'b1;
      cnt     <= '0;
      curLen  <= nextLen;
      clkQ    <= (nextLen >> 1) != '0;
    end else begin
      cnt     <= cnt + 1'b1;
      clkQ    <= (cnt + 1'b1) < (curLen >> 1);
    end
  end

  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (nextLen >= LEN_W'(2))); // R8

  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strobe.step) |=> $stable(curLen)); // R10

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !divClk); // R11

  AST_RISE_AT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divClk) |-> $past(strobe.step)); // R9

endmodule

// File: rtl/mash_clk_div.sv
module mash_clk_div
  import mash_div_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    en,
  input  logic [INT_W+FRAC_W-1:0] divWord,
  input  logic [1:0]              modeSel,
  output logic                    divClk
);

  localparam int LEN_W = INT_W + 1;
  localparam logic [LEN_W:0] K1 = 1;
  localparam logic [LEN_W:0] K2 = 2;
  localparam logic [LEN_W:0] K3 = 3;
  localparam logic [LEN_W:0] K4 = 4;
  localparam logic [LEN_W:0] K5 = 5;

  divStrobe_t       strobe;
  logic [LEN_W-1:0] nextLen;
  divMode_e         mode;

  assign mode = divMode_e'(modeSel);

  mash_div_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .nextLen (nextLen),
    .strobe  (strobe),
    .divClk  (divClk)
  );

  mash_div_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LEN_W(LEN_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divWord (divWord),
    .mode    (mode),
    .nextLen (nextLen)
  );

  logic [LEN_W:0] lenX;
  logic [LEN_W:0] intX;
  assign lenX = {1'b0, nextLen};
  assign intX = {2'b00, divWord[FRAC_W +: INT_W]};

  AST_INT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && mode == MODE_INT && intX >= K2) |-> (lenX == intX)); // R2

  AST_FRAC1_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && mode == MODE_FRAC1 && intX >= K2)
      |-> (lenX >= intX && lenX <= intX + K1)); // R3

  AST_MASH2_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && mode == MODE_MASH2 && intX >= K3)
      |-> (lenX + K1 >= intX && lenX <= intX + K2)); // R5

  AST_MASH3_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && mode == MODE_MASH3 && intX >= K5)
      |-> (lenX + K3 >= intX && lenX <= intX + K4)); // R6

endmodule

// File: tb/mash_clk_div_tb_top.sv
module mash_clk_div_tb_top;

  localparam int CAP = 4200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [23:0] divWord = '0;
  logic [1:0]  modeSel = '0;
  logic        divClk;

  always #5 clk = ~clk;

  mash_clk_div dut_i (
    .clk(clk), .rstN(rstN), .en(en), .divWord(divWord),
    .modeSel(modeSel), .divClk(divClk)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lenArr [CAP];
  int hiArr  [CAP];
  int capCount = 0;
  int runLen = 0;
  int runHi = 0;
  bit inPer = 0;
  bit prevClk = 0;
  int epoch = 0;
  int seenEpoch = 0;

  // period monitor, samples away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (epoch != seenEpoch) begin
      seenEpoch = epoch;
      capCount = 0;
      inPer = 0;
    end
    if (divClk && !prevClk) begin
      if (inPer && capCount < CAP) begin
        lenArr[capCount] = runLen;
        hiArr[capCount] = runHi;
        capCount++;
      end
      inPer = 1;
      runLen = 1;
      runHi = 1;
    end else if (inPer) begin
      runLen++;
      if (divClk) runHi++;
    end
    prevClk = divClk;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic startRun(input int iPart, input int fPart, input int mode);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    divWord = {iPart[11:0], fPart[11:0]};
    modeSel = mode[1:0];
    epoch++;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic waitPeriods(input int n);
    while (capCount < n) @(posedge clk);
  endtask

  function automatic int frac1Len(input int iPart, input int fPart, input int n);
    return iPart + ((n * fPart) >> 12) - (((n - 1) * fPart) >> 12);
  endfunction

  task automatic checkDuty(input string req, input int count);
    int bad = 0;
    int badIdx = 0;
    for (int k = 0; k < count; k++) begin
      if (hiArr[k] != lenArr[k] / 2) begin
        if (bad == 0) badIdx = k;
        bad++;
      end
    end
    chk(bad == 0, req, hiArr[badIdx], lenArr[badIdx] / 2);
  endtask

  initial begin
    // reset state, R11
    repeat (3) @(negedge clk);
    chk(divClk == 1'b0, "R11 reset output low", int'(divClk), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(divClk == 1'b0, "R11 idle with enable low", int'(divClk), 0);

    // R2/R1: integer mode ignores the fraction
    startRun(7, 'h555, 0);
    waitPeriods(6);
    for (int k = 0; k < 6; k++) chk(lenArr[k] == 7, "R2 integer period", lenArr[k], 7);
    for (int k = 0; k < 6; k++) chk(hiArr[k] == 3, "R9 high time of 7", hiArr[k], 3);

    // R8: clamp to 2
    startRun(1, 0, 0);
    waitPeriods(4);
    for (int k = 0; k < 4; k++) chk(lenArr[k] == 2, "R8 clamp I=1", lenArr[k], 2);
    chk(hiArr[0] == 1, "R9 high time of 2", hiArr[0], 1);
    startRun(0, 'h800, 0);
    waitPeriods(4);
    for (int k = 0; k < 4; k++) chk(lenArr[k] == 2, "R8 clamp I=0", lenArr[k], 2);

    // R3/R4: first order, full wrap plus one
    begin
      int iP = 5;
      int fP = 'h9AB;
      int sumA = 0;
      int sumB = 0;
      startRun(iP, fP, 1);
      waitPeriods(4097);
      for (int k = 0; k < 4097; k++)
        chk(lenArr[k] == frac1Len(iP, fP, k + 1), "R3 first order period",
            lenArr[k], frac1Len(iP, fP, k + 1));
      for (int k = 0; k < 4096; k++) sumA += lenArr[k];
      for (int k = 1; k < 4097; k++) sumB += lenArr[k];
      chk(sumA == 4096 * iP + fP, "R4 window from period 1", sumA, 4096 * iP + fP);
      chk(sumB == 4096 * iP + fP, "R4 window from period 2", sumB, 4096 * iP + fP);
      checkDuty("R9 first order duty", 4097);
    end

    // R5/R7: second order
    begin
      int iP = 6;
      int fP = 'h7A1;
      int sumA = 0;
      startRun(iP, fP, 2);
      waitPeriods(4096);
      for (int k = 0; k < 4096; k++) chkRange("R5 second order period", lenArr[k], iP - 1, iP + 2);
      for (int k = 0; k < 4096; k++) sumA += lenArr[k];
      chkRange("R7 second order total", sumA, 4096 * iP + fP - 1, 4096 * iP + fP + 2);
      checkDuty("R9 second order duty", 4096);
    end

    // R6/R7: third order
    begin
      int iP = 8;
      int fP = 'h3C7;
      int sumA = 0;
      startRun(iP, fP, 3);
      waitPeriods(4096);
      for (int k = 0; k < 4096; k++) chkRange("R6 third order period", lenArr[k], iP - 3, iP + 4);
      for (int k = 0; k < 4096; k++) sumA += lenArr[k];
      chkRange("R7 third order total", sumA, 4096 * iP + fP - 1, 4096 * iP + fP + 2);
      checkDuty("R9 third order duty", 4096);
    end

    // R12: no spread with zero fraction
    startRun(9, 0, 3);
    waitPeriods(20);
    for (int k = 0; k < 20; k++) chk(lenArr[k] == 9, "R12 third order F=0", lenArr[k], 9);
    startRun(9, 0, 2);
    waitPeriods(20);
    for (int k = 0; k < 20; k++) chk(lenArr[k] == 9, "R12 second order F=0", lenArr[k], 9);

    // R8: third order near the floor
    startRun(3, 'h801, 3);
    waitPeriods(300);
    for (int k = 0; k < 300; k++) chkRange("R8 third order floor", lenArr[k], 2, 7);
    checkDuty("R9 clamped duty", 300);

    // R10: change inside a period
    startRun(10, 'h777, 0);
    waitPeriods(2);
    repeat (2) @(negedge clk);
    divWord = {12'd4, 12'h777};
    waitPeriods(5);
    chk(lenArr[2] == 10, "R10 current period kept", lenArr[2], 10);
    chk(lenArr[3] == 4, "R10 next period uses new value", lenArr[3], 4);

    // R11: disable, output low, modulator restarts from zero
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(divClk == 1'b0, "R11 low after disable", int'(divClk), 0);
    begin
      int highSeen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (divClk) highSeen++;
      end
      chk(highSeen == 0, "R11 stays low while disabled", highSeen, 0);
    end
    startRun(4, 'h123, 1);
    waitPeriods(40);
    for (int k = 0; k < 40; k++)
      chk(lenArr[k] == frac1Len(4, 'h123, k + 1), "R11 restart sequence",
          lenArr[k], frac1Len(4, 'h123, k + 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule